// File: doc/BRIEF.md
# Transmit Descriptor Ring Ownership Engine

This block walks a circular ring of transmit descriptors that sit in a small local descriptor store. Each entry carries four flags and a buffer length: an ownership flag (set by the host when the entry is ready for the engine), a frame-start flag, a frame-end flag, a kill flag, and a byte count. The host fills entries through a write port. The engine issues one data-DMA command for each owned buffer that holds data. When that command finishes, the engine clears the ownership flag, which is the only write-back it ever performs, and moves its ring pointer on.

The engine does not fault on unusual rings. It drops stray continuation entries and zero-length buffers. When a frame continues into an entry the host has not yet released, it raises a chain-mode flag and waits for polls. After a discarding error or a kill it drains the rest of the frame. It reports each underflow with a one-cycle pulse and, under a control input, either retries the buffer or discards the frame.

The controller has six states: WAIT (idle until `poll_req`), FETCH (examine the current entry), ISSUE (send the DMA command), PEEK (read the ownership of the following entry between the data transfers), XFER (wait for `dma_done` or `tx_err`) and SKIP (drain the rest of a failed frame). The transitions are as follows:
- WAIT→FETCH on a poll.
- FETCH→WAIT when the entry is not owned.
- FETCH→FETCH after a stray or zero-length drop, or after a kill at a frame end.
- FETCH→SKIP after a kill in mid-frame.
- FETCH→ISSUE when the entry holds data.
- ISSUE→PEEK, then PEEK→XFER, unconditionally.
- XFER→FETCH at a frame end, or in mid-frame when the following entry was seen owned.
- XFER→WAIT in mid-frame when it was not.
- XFER→ISSUE on an underflow retry.
- XFER→SKIP on a mid-frame discard.
- SKIP→SKIP while continuation entries remain.
- SKIP→FETCH once the drain stops.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset no DMA command, write-back, chain flag or underrun pulse is active, and the first entry examined is index 0.
- R2: A poll that finds the current entry not owned produces no DMA command and no write-back, and the same entry is examined again at the next poll.
- R3: An owned entry with the frame-start flag clear, found outside a frame, is handed back at once (wb_valid with its index, no DMA), and the next entry is examined without a poll.
- R4: An owned entry of length 0 is handed back without a DMA command, in any position of a frame. If its frame-end flag is set, the frame ends there. No DMA command ever carries length 0.
- R5: An owned entry with data (frame-start set, or any entry inside a frame) produces exactly one DMA command carrying its index and length. Only after `dma_done` is that entry handed back and the pointer advanced. A DMA command and a write-back never share a cycle.
- R6: The pointer wraps from entry RING_SIZE-1 to entry 0.
- R7: When a buffer with the frame-end flag clear completes and the following entry was not owned, `chain_mode` is high while the engine waits. The next poll resumes the frame and clears `chain_mode`.
- R8: A non-underflow `tx_err` in mid-frame hands back the current entry. The engine then hands back each following entry that is owned with frame-start clear, and stops at an entry that is not owned or has frame-start set. It issues no DMA for the drained entries.
- R9: An owned entry with the kill flag set, and with data or at a frame start, is handed back without a DMA command. If its frame-end flag is clear, the rest of the frame is drained as in R8.
- R10: An underflow (`tx_err` with `tx_err_uflo`) pulses `underrun_inc` for one cycle. With `retry_on_uflo` low, the frame is discarded as in R8, and the write-back of the current entry happens in the same cycle as the pulse. With `retry_on_uflo` high, there is no write-back, and the same buffer's DMA command is issued again on the next cycle.
- R11: After a frame ends, whether it succeeded, failed or was killed, the next entry is examined without waiting for a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes one descriptor entry |
| host_wr_idx | input | IDX_W | Entry index written |
| host_wr_own | input | 1 | Ownership flag (1 = engine may use it) |
| host_wr_stp | input | 1 | Frame-start flag |
| host_wr_enp | input | 1 | Frame-end flag |
| host_wr_kill | input | 1 | Kill flag |
| host_wr_len | input | LEN_W | Buffer length in bytes |
| poll_req | input | 1 | Poll pulse |
| retry_on_uflo | input | 1 | 1 = retry the buffer after underflow, 0 = discard |
| dma_done | input | 1 | Current data DMA finished |
| tx_err | input | 1 | Transfer error for the current buffer |
| tx_err_uflo | input | 1 | Qualifies tx_err as underflow |
| dma_cmd_valid | output | 1 | DMA command pulse |
| dma_cmd_idx | output | IDX_W | Entry index of the command |
| dma_cmd_len | output | LEN_W | Buffer length of the command |
| wb_valid | output | 1 | Ownership flag of wb_idx cleared this cycle |
| wb_idx | output | IDX_W | Entry handed back |
| chain_mode | output | 1 | Waiting mid-frame for a not-yet-owned entry |
| underrun_inc | output | 1 | Underrun counter increment |

## Verification
The bench builds the engine with RING_SIZE = 4 and LEN_W = 8. A four-entry ring lets a short sequence of frames cross the wrap from entry 3 to entry 0 several times. It also places stray, zero-length, killed and error-drained entries on both sides of that wrap. An owned entry one step ahead is quick to arrange or withhold, which is what the chain-wait and drain-stop cases need.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_FETCH,
        ST_ISSUE,
        ST_PEEK,
        ST_XFER,
        ST_SKIP
    } txr_state_e;

    typedef struct packed {
        logic own;
        logic stp;
        logic enp;
        logic kill;
    } txr_flags_t;

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem
    import txr_pkg::*;
#(
    parameter int RING_SIZE = 8,
    parameter int IDX_W     = 3,
    parameter int LEN_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  txr_flags_t       host_flags,
    input  logic [LEN_W-1:0] host_len,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_a_idx,
    output txr_flags_t       rd_a_flags,
    output logic [LEN_W-1:0] rd_a_len,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b_own
);

    txr_flags_t       flg [RING_SIZE];
    logic [LEN_W-1:0] len [RING_SIZE];

    for (genvar g = 0; g < RING_SIZE; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flg[g] <= '0;
                len[g] <= '0;
            end else if (host_we && host_idx == IDX_W'(g)) begin
                flg[g] <= host_flags;
                len[g] <= host_len;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                flg[g].own <= 1'b0;
            end
        end
    end

    assign rd_a_flags = flg[rd_a_idx];
    assign rd_a_len   = len[rd_a_idx];
    assign rd_b_own   = flg[rd_b_idx].own;

endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int RING_SIZE = 8,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] nxt_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_SIZE - 1);

    assign nxt_idx = (cur_idx == LAST) ? '0 : cur_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)   cur_idx <= '0;
        else if (adv) cur_idx <= nxt_idx;
    end

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  txr_flags_t       cur_flags,
    input  logic [LEN_W-1:0] cur_len,
    input  logic             nxt_own,
    input  logic             poll_req,
    input  logic             retry_on_uflo,
    input  logic             dma_done,
    input  logic             tx_err,
    input  logic             tx_err_uflo,
    output logic             adv,
    output logic             clr_en,
    output logic             dma_cmd_valid,
    output logic             chain_mode,
    output logic             underrun_inc
);

    txr_state_e st, st_n;
    logic in_frame, in_frame_n;
    logic peek_own, peek_own_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_WAIT;
            in_frame <= 1'b0;
            peek_own <= 1'b0;
        end else begin
            st       <= st_n;
            in_frame <= in_frame_n;
            peek_own <= peek_own_n;
        end
    end

    always_comb begin
        st_n          = st;
        in_frame_n    = in_frame;
        peek_own_n    = peek_own;
        adv           = 1'b0;
        clr_en        = 1'b0;
        dma_cmd_valid = 1'b0;
        chain_mode    = 1'b0;
        underrun_inc  = 1'b0;
        unique case (st)
            ST_WAIT: begin
                chain_mode = in_frame;
                if (poll_req) st_n = ST_FETCH;
            end
            ST_FETCH: begin
                if (!cur_flags.own) begin
                    st_n = ST_WAIT;
                end else if (!in_frame && !cur_flags.stp) begin
                    clr_en = 1'b1;
                    adv    = 1'b1;
                end else if (cur_flags.kill) begin
                    clr_en = 1'b1;
                    adv    = 1'b1;
                    if (cur_flags.enp) in_frame_n = 1'b0;
                    else               st_n       = ST_SKIP;
                end else if (cur_len == '0) begin
                    clr_en     = 1'b1;
                    adv        = 1'b1;
                    in_frame_n = !cur_flags.enp;
                end else begin
                    st_n = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                dma_cmd_valid = 1'b1;
                in_frame_n    = 1'b1;
                st_n          = ST_PEEK;
            end
            ST_PEEK: begin
                peek_own_n = nxt_own;
                st_n       = ST_XFER;
            end
            ST_XFER: begin
                if (tx_err) begin
                    underrun_inc = tx_err_uflo;
                    if (tx_err_uflo && retry_on_uflo) begin
                        st_n = ST_ISSUE;
                    end else begin
                        clr_en = 1'b1;
                        adv    = 1'b1;
                        if (cur_flags.enp) begin
                            in_frame_n = 1'b0;
                            st_n       = ST_FETCH;
                        end else begin
                            st_n = ST_SKIP;
                        end
                    end
                end else if (dma_done) begin
                    clr_en = 1'b1;
                    adv    = 1'b1;
                    if (cur_flags.enp) begin
                        in_frame_n = 1'b0;
                        st_n       = ST_FETCH;
                    end else if (peek_own) begin
                        st_n = ST_FETCH;
                    end else begin
                        st_n = ST_WAIT;
                    end
                end
            end
            ST_SKIP: begin
                if (cur_flags.own && !cur_flags.stp) begin
                    clr_en = 1'b1;
                    adv    = 1'b1;
                end else begin
                    in_frame_n = 1'b0;
                    st_n       = ST_FETCH;
                end
            end
            default: st_n = ST_WAIT;
        endcase
    end

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import txr_pkg::*;
#(
    parameter int RING_SIZE = 8,
    parameter int LEN_W     = 12,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [IDX_W-1:0] host_wr_idx,
    input  logic             host_wr_own,
    input  logic             host_wr_stp,
    input  logic             host_wr_enp,
    input  logic             host_wr_kill,
    input  logic [LEN_W-1:0] host_wr_len,
    input  logic             poll_req,
    input  logic             retry_on_uflo,
    input  logic             dma_done,
    input  logic             tx_err,
    input  logic             tx_err_uflo,
    output logic             dma_cmd_valid,
    output logic [IDX_W-1:0] dma_cmd_idx,
    output logic [LEN_W-1:0] dma_cmd_len,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic             chain_mode,
    output logic             underrun_inc
);

    logic [IDX_W-1:0] cur_idx, nxt_idx;
    txr_flags_t       cur_flags, host_flags;
    logic [LEN_W-1:0] cur_len;
    logic             nxt_own, adv, clr_en;

    assign host_flags = '{own: host_wr_own, stp: host_wr_stp,
                          enp: host_wr_enp, kill: host_wr_kill};

    txr_desc_mem #(.RING_SIZE(RING_SIZE), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr_en),
        .host_idx   (host_wr_idx),
        .host_flags (host_flags),
        .host_len   (host_wr_len),
        .clr_en     (clr_en),
        .clr_idx    (cur_idx),
        .rd_a_idx   (cur_idx),
        .rd_a_flags (cur_flags),
        .rd_a_len   (cur_len),
        .rd_b_idx   (nxt_idx),
        .rd_b_own   (nxt_own)
    );

    txr_ring_ptr #(.RING_SIZE(RING_SIZE), .IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .cur_idx (cur_idx),
        .nxt_idx (nxt_idx)
    );

    txr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_flags     (cur_flags),
        .cur_len       (cur_len),
        .nxt_own       (nxt_own),
        .poll_req      (poll_req),
        .retry_on_uflo (retry_on_uflo),
        .dma_done      (dma_done),
        .tx_err        (tx_err),
        .tx_err_uflo   (tx_err_uflo),
        .adv           (adv),
        .clr_en        (clr_en),
        .dma_cmd_valid (dma_cmd_valid),
        .chain_mode    (chain_mode),
        .underrun_inc  (underrun_inc)
    );

    assign dma_cmd_idx = cur_idx;
    assign dma_cmd_len = cur_len;
    assign wb_valid    = clr_en;
    assign wb_idx      = cur_idx;

endmodule

// File: rtl/txr_chk.sv
module txr_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dma_cmd_valid,
    input logic [LEN_W-1:0] dma_cmd_len,
    input logic             wb_valid,
    input logic             chain_mode,
    input logic             underrun_inc,
    input logic             retry_on_uflo
);

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd_valid |-> dma_cmd_len != '0);

    // R5
    cmd_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_cmd_valid && wb_valid));

    // R5
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_cmd_valid |=> !dma_cmd_valid);

    // R7
    chain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_mode |-> (!dma_cmd_valid && !wb_valid));

    // R10
    uflo_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_inc && !retry_on_uflo) |-> wb_valid);

    // R10
    uflo_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_inc && retry_on_uflo) |=> dma_cmd_valid);

endmodule

bind tx_ring_engine txr_chk #(.LEN_W(LEN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_cmd_valid (dma_cmd_valid),
    .dma_cmd_len   (dma_cmd_len),
    .wb_valid      (wb_valid),
    .chain_mode    (chain_mode),
    .underrun_inc  (underrun_inc),
    .retry_on_uflo (retry_on_uflo)
);

// File: tb/tx_ring_engine_tb.sv
`timescale 1ns/1ps
module tx_ring_engine_tb;

    localparam int RS = 4;
    localparam int LW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [IW-1:0] host_wr_idx = '0;
    logic          host_wr_own = 1'b0, host_wr_stp = 1'b0;
    logic          host_wr_enp = 1'b0, host_wr_kill = 1'b0;
    logic [LW-1:0] host_wr_len = '0;
    logic          poll_req = 1'b0, retry_on_uflo = 1'b0;
    logic          dma_done = 1'b0, tx_err = 1'b0, tx_err_uflo = 1'b0;
    logic          dma_cmd_valid, wb_valid, chain_mode, underrun_inc;
    logic [IW-1:0] dma_cmd_idx, wb_idx;
    logic [LW-1:0] dma_cmd_len;

    always #4 clk = ~clk;

    tx_ring_engine #(.RING_SIZE(RS), .LEN_W(LW)) u_dut (.*);

    typedef struct packed {
        logic [1:0]    kind;   // 0 dma, 1 wb, 2 underrun
        logic [IW-1:0] idx;
        logic [LW-1:0] len;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];
    int    plan_q[$];
    int    checks = 0;
    int    fails  = 0;

    task automatic expect_ev(input logic [1:0] k, input int i, input int l, input string tag);
        exp_q.push_back('{kind: k, idx: IW'(i), len: LW'(l)});
        tag_q.push_back(tag);
    endtask

    task automatic cmp(input logic [1:0] k, input logic [IW-1:0] i, input logic [LW-1:0] l);
        ev_t   e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected event kind=%0d idx=%0d len=%0d, expected none", k, i, l);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.kind != k || e.idx != i || (k == 2'd0 && e.len != l)) begin
                fails++;
                $display("FAIL %s: got kind=%0d idx=%0d len=%0d, expected kind=%0d idx=%0d len=%0d",
                         t, k, i, l, e.kind, e.idx, e.len);
            end
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (underrun_inc)  cmp(2'd2, '0, '0);
                if (wb_valid)      cmp(2'd1, wb_idx, '0);
                if (dma_cmd_valid) cmp(2'd0, dma_cmd_idx, dma_cmd_len);
            end
        end
    end

    // DMA responder: 0 done, 1 error, 2 underflow
    initial begin
        @(negedge clk);
        forever begin
            if (dma_cmd_valid) begin
                int act;
                act = (plan_q.size() > 0) ? plan_q.pop_front() : 0;
                repeat (3) @(negedge clk);
                if (act == 0) dma_done = 1'b1;
                else begin
                    tx_err      = 1'b1;
                    tx_err_uflo = (act == 2);
                end
                @(negedge clk);
                dma_done = 1'b0; tx_err = 1'b0; tx_err_uflo = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic wr(input int i, input bit o, input bit s, input bit e, input bit k, input int l);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_idx = IW'(i);
        host_wr_own = o; host_wr_stp = s; host_wr_enp = e; host_wr_kill = k;
        host_wr_len = LW'(l);
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic poll();
        @(negedge clk);
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int n = 0; n < 200 && exp_q.size() != 0; n++) @(negedge clk);
        repeat (8) @(negedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected events missing, expected 0", tag, exp_q.size());
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        chk_bit("R1 dma", dma_cmd_valid, 1'b0);
        chk_bit("R1 wb", wb_valid, 1'b0);
        chk_bit("R1 chain", chain_mode, 1'b0);
        chk_bit("R1 underrun", underrun_inc, 1'b0);

        // R2 poll with nothing owned
        poll();
        drain("R2");
        chk_bit("R2 chain", chain_mode, 1'b0);

        // R1 / R5 / R11 single frame at index 0, same entry re-examined
        wr(0, 1, 1, 1, 0, 64);
        expect_ev(0, 0, 64, "R1 R5 first frame");
        expect_ev(1, 0, 0, "R5 handback");
        poll();
        drain("R5");

        // R5 / R11 two-buffer frame
        wr(1, 1, 1, 0, 0, 10);
        wr(2, 1, 0, 1, 0, 20);
        expect_ev(0, 1, 10, "R5 buf1");
        expect_ev(1, 1, 0, "R5 wb1");
        expect_ev(0, 2, 20, "R5 buf2");
        expect_ev(1, 2, 0, "R11 wb2");
        poll();
        drain("R11");

        // R4 zero-length start, R6 wrap to 0
        wr(3, 1, 1, 0, 0, 0);
        wr(0, 1, 0, 1, 0, 30);
        expect_ev(1, 3, 0, "R4 zero skip");
        expect_ev(0, 0, 30, "R6 wrap");
        expect_ev(1, 0, 0, "R6 wb");
        poll();
        drain("R4");

        // R3 stray continuation
        wr(1, 1, 0, 0, 0, 5);
        expect_ev(1, 1, 0, "R3 stray");
        poll();
        drain("R3");

        // R7 chain wait
        wr(2, 1, 1, 0, 0, 8);
        expect_ev(0, 2, 8, "R7 head");
        expect_ev(1, 2, 0, "R7 head wb");
        poll();
        drain("R7");
        chk_bit("R7 chain set", chain_mode, 1'b1);
        wr(3, 1, 0, 1, 0, 9);
        expect_ev(0, 3, 9, "R7 resume");
        expect_ev(1, 3, 0, "R7 resume wb");
        poll();
        drain("R7 resume");
        chk_bit("R7 chain clear", chain_mode, 1'b0);

        // R8 error drain stops at not-owned
        wr(0, 1, 1, 0, 0, 4);
        wr(1, 1, 0, 0, 0, 4);
        wr(2, 1, 0, 1, 0, 4);
        plan_q.push_back(1);
        expect_ev(0, 0, 4, "R8 head");
        expect_ev(1, 0, 0, "R8 err wb");
        expect_ev(1, 1, 0, "R8 drain1");
        expect_ev(1, 2, 0, "R8 drain2");
        poll();
        drain("R8");

        // R9 kill, drain stops at next frame start
        wr(3, 1, 1, 0, 1, 7);
        wr(0, 1, 0, 0, 0, 3);
        wr(1, 1, 1, 1, 0, 2);
        expect_ev(1, 3, 0, "R9 kill");
        expect_ev(1, 0, 0, "R9 drain");
        expect_ev(0, 1, 2, "R9 next frame");
        expect_ev(1, 1, 0, "R9 next wb");
        poll();
        drain("R9");

        // R10 underflow discard
        wr(2, 1, 1, 1, 0, 6);
        plan_q.push_back(2);
        expect_ev(0, 2, 6, "R10 dma");
        expect_ev(2, 0, 0, "R10 uflo");
        expect_ev(1, 2, 0, "R10 discard wb");
        poll();
        drain("R10 discard");

        // R10 underflow retry
        retry_on_uflo = 1'b1;
        wr(3, 1, 1, 1, 0, 11);
        plan_q.push_back(2);
        plan_q.push_back(0);
        expect_ev(0, 3, 11, "R10 dma");
        expect_ev(2, 0, 0, "R10 uflo retry");
        expect_ev(0, 3, 11, "R10 reissue");
        expect_ev(1, 3, 0, "R10 retry wb");
        poll();
        drain("R10 retry");
        retry_on_uflo = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule